// File: doc/BRIEF.md
# DRAM Self-Refresh Sequencer

This block sits on the controller side of a DDR2-style memory interface. It puts the DRAM into its low-power self-refresh state and brings it back out. A power manager raises a sleep request. The sequencer then takes the command bus from the normal scheduler and issues a precharge-all. After the row-precharge wait it drops CKE together with the self-refresh entry command. From the cycle after entry, it tells the clock generator that the memory clock may be stopped.

On a wake request, the sequencer waits for the clock generator to report a stable clock, and it also waits out the minimum residency. It then raises CKE and keeps the bus at NOP for the exit-to-command delay. Next it issues one mandatory auto refresh. It hands the bus back through `ready` only after the longer exit-hold time has also run out.

Every wait is a programmable cycle count, and ODT is held low whenever the sequencer owns the bus. A sleep request that is held across an exit is accepted only after the refresh and its refresh-cycle wait have finished. This guarantees one refresh between two self-refresh periods.

Top module: `dram_selfref_seq`

## Requirements
- R1: Out of reset the block is in its ready state: `ready`=1, `cke`=1, command NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1), `clk_stop_ok`=0. In that state `wake_req` has no effect on any output.
- R2: A `sleep_req` seen high in a cycle where the block is in its ready state produces the precharge-all command (0,0,1,0) in the next cycle.
- R3: The self-refresh entry command (0,0,0,1 with `cke`=0) follows the precharge exactly max(`cfg_pre_wait`,2) cycles later, with NOP in between.
- R4: `odt` equals `odt_req` while `ready` is high and is 0 whenever `ready` is low.
- R5: `cke` stays low from the entry cycle on. It rises at the later of entry+max(`cfg_min_sleep`,2) and one cycle after the first cycle in which `wake_req` and `clk_stable` are both high.
- R6: `clk_stop_ok` is high exactly in the cycles after the entry cycle while `cke` is low and `wake_req` is low.
- R7: From the cycle `cke` rises, every command is NOP until the refresh, which comes exactly max(`cfg_exit_cmd`,1) cycles after the rise.
- R8: Exactly one auto refresh command (0,0,0,1 with `cke`=1) is issued per exit.
- R9: `ready` first rises in cycle max(refresh+1, rise+max(`cfg_exit_hold`-1,0)), and `cke` stays high from the rise on.
- R10: A `sleep_req` held through the exit gives the next precharge in cycle max(refresh+max(`cfg_ref_wait`-1,1), rise+max(`cfg_exit_hold`-1,0))+2. A precharge is never issued without a refresh since the last entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Level request to enter self-refresh |
| wake_req | input | 1 | Level request to leave self-refresh |
| clk_stable | input | 1 | Memory clock is running and stable |
| odt_req | input | 1 | ODT value wanted by the normal scheduler |
| cfg_pre_wait | input | CNT_W | Precharge-to-entry cycles |
| cfg_min_sleep | input | CNT_W | Minimum cycles with CKE low |
| cfg_exit_cmd | input | CNT_W | CKE-rise to first valid command cycles |
| cfg_exit_hold | input | CNT_W | CKE-rise to bus release cycles |
| cfg_ref_wait | input | CNT_W | Refresh-to-next-command cycles |
| cs_n | output | 1 | DRAM chip select, active low |
| ras_n | output | 1 | DRAM row strobe, active low |
| cas_n | output | 1 | DRAM column strobe, active low |
| we_n | output | 1 | DRAM write enable, active low |
| cke | output | 1 | DRAM clock enable |
| odt | output | 1 | DRAM on-die termination |
| clk_stop_ok | output | 1 | Memory clock may be stopped or changed |
| ready | output | 1 | Normal scheduler owns the command bus |

## Verification
The sequence is run with mid-range waits, with every wait set to 1 or 2, with a wake that arrives before the clock is stable, and twice with the sleep request held across the exit. The minimum settings separate the clamped gaps from raw counts. The late clock-stable case shows whether CKE waits for the clock and not only for the wake. The two held-request cases differ in which wait is the longer one: a long exit-hold time in one and a long refresh wait in the other. This shows whether re-entry waits for both the refresh and the exit-hold time.

// File: rtl/sr_pkg.sv
`timescale 1ns/1ps
package sr_pkg;

  typedef enum logic [2:0] {
    ST_READY,  // scheduler owns the bus
    ST_PRE,    // precharge-all on the bus
    ST_WRP,    // precharge wait
    ST_ENTER,  // entry command, CKE drops
    ST_RES,    // resident in self-refresh
    ST_XIT,    // CKE high, NOP fill
    ST_REF,    // mandatory refresh
    ST_RFW     // refresh wait
  } sr_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } dram_cmd_t;

  localparam dram_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam dram_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam dram_cmd_t CMD_RFS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

  // Wait state placed between two commands that must be n cycles apart:
  // the state lasts load+1 cycles, so load = n-2 (minimum gap 2).
  function automatic int gap_load(int n);
    return (n > 2) ? n - 2 : 0;
  endfunction

  // Interval whose first cycle is the state's own first cycle:
  // the span is load+1 cycles, so load = n-1 (minimum span 1).
  function automatic int span_load(int n);
    return (n > 1) ? n - 1 : 0;
  endfunction

endpackage

// File: rtl/sr_timer.sv
`timescale 1ns/1ps
module sr_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sr_cmd_decode.sv
`timescale 1ns/1ps
module sr_cmd_decode
  import sr_pkg::*;
(
  input  sr_state_e state,
  input  logic      hold_done,
  input  logic      wake_req,
  input  logic      odt_req,
  output dram_cmd_t cmd,
  output logic      cke,
  output logic      odt,
  output logic      clk_stop_ok,
  output logic      ready
);
  always_comb begin
    cmd = CMD_NOP;
    cke = 1'b1;
    unique case (state)
      ST_PRE:   cmd = CMD_PRE;
      ST_ENTER: begin cmd = CMD_RFS; cke = 1'b0; end
      ST_RES:   cke = 1'b0;
      ST_REF:   cmd = CMD_RFS;
      default:  cmd = CMD_NOP;
    endcase
  end

  assign ready       = (state == ST_READY) || ((state == ST_RFW) && hold_done);
  assign odt         = ready && odt_req;
  assign clk_stop_ok = (state == ST_RES) && !wake_req;
endmodule

// File: rtl/dram_selfref_seq.sv
`timescale 1ns/1ps
module dram_selfref_seq
  import sr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             wake_req,
  input  logic             clk_stable,
  input  logic             odt_req,
  input  logic [CNT_W-1:0] cfg_pre_wait,
  input  logic [CNT_W-1:0] cfg_min_sleep,
  input  logic [CNT_W-1:0] cfg_exit_cmd,
  input  logic [CNT_W-1:0] cfg_exit_hold,
  input  logic [CNT_W-1:0] cfg_ref_wait,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             cke,
  output logic             odt,
  output logic             clk_stop_ok,
  output logic             ready
);
  sr_state_e state_q, state_d;
  logic             step_done, hold_done;
  logic             step_load, hold_load;
  logic [CNT_W-1:0] step_val,  hold_val;
  dram_cmd_t        cmd;

  // named events for the checker and waveforms
  logic ev_sleep_accept, ev_exit_start, ev_wake_ok;
  assign ev_wake_ok      = wake_req && clk_stable;
  assign ev_sleep_accept = (state_q == ST_READY) && sleep_req;
  assign ev_exit_start   = (state_q == ST_RES) && step_done && ev_wake_ok;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_READY: if (sleep_req)              state_d = ST_PRE;
      ST_PRE:                               state_d = ST_WRP;
      ST_WRP:   if (step_done)              state_d = ST_ENTER;
      ST_ENTER:                             state_d = ST_RES;
      ST_RES:   if (ev_exit_start)          state_d = ST_XIT;
      ST_XIT:   if (step_done)              state_d = ST_REF;
      ST_REF:                               state_d = ST_RFW;
      ST_RFW:   if (step_done && hold_done) state_d = ST_READY;
      default:                              state_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_READY;
    else        state_q <= state_d;
  end

  // Step timer: reloaded on every state change with the wait of the new state.
  assign step_load = (state_d != state_q);
  always_comb begin
    unique case (state_d)
      ST_WRP:  step_val = CNT_W'(gap_load(int'(cfg_pre_wait)));
      ST_RES:  step_val = CNT_W'(gap_load(int'(cfg_min_sleep)));
      ST_XIT:  step_val = CNT_W'(span_load(int'(cfg_exit_cmd)));
      ST_RFW:  step_val = CNT_W'(gap_load(int'(cfg_ref_wait)));
      default: step_val = '0;
    endcase
  end

  // Hold timer: started when CKE rises, runs across exit, refresh and refresh wait.
  assign hold_load = (state_d == ST_XIT) && (state_q != ST_XIT);
  assign hold_val  = CNT_W'(span_load(int'(cfg_exit_hold)));

  sr_timer #(.W(CNT_W)) u_step (
    .clk(clk), .rst_n(rst_n), .load(step_load), .load_val(step_val), .done(step_done)
  );

  sr_timer #(.W(CNT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(hold_load), .load_val(hold_val), .done(hold_done)
  );

  sr_cmd_decode u_dec (
    .state(state_q), .hold_done(hold_done), .wake_req(wake_req), .odt_req(odt_req),
    .cmd(cmd), .cke(cke), .odt(odt), .clk_stop_ok(clk_stop_ok), .ready(ready)
  );

  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;
endmodule

// File: rtl/sr_checker.sv
`timescale 1ns/1ps
module sr_checker (
  input logic clk,
  input logic rst_n,
  input logic wake_req,
  input logic clk_stable,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic cke,
  input logic odt,
  input logic clk_stop_ok,
  input logic ready
);
  logic [3:0] code;
  logic is_pre, is_entry, is_refresh, is_nop, refreshed_q;
  assign code       = {cs_n, ras_n, cas_n, we_n};
  assign is_pre     = (code == 4'b0010);
  assign is_entry   = (code == 4'b0001) && !cke;
  assign is_refresh = (code == 4'b0001) && cke;
  assign is_nop     = (code == 4'b0111);

  // refresh seen since the last entry command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          refreshed_q <= 1'b1;
    else if (is_refresh) refreshed_q <= 1'b1;
    else if (is_entry)   refreshed_q <= 1'b0;
  end

  assert_ready_cke_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> cke);
  assert_entry_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_entry |-> (!odt && !ready));
  assert_odt_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !odt);
  assert_cke_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> is_entry);
  assert_cke_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> ($past(wake_req) && $past(clk_stable)));
  assert_clk_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop_ok |-> (!cke && !is_entry && !wake_req));
  assert_exit_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> is_nop);
  assert_refresh_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> refreshed_q);
endmodule

bind dram_selfref_seq sr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .clk_stable(clk_stable),
  .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke),
  .odt(odt), .clk_stop_ok(clk_stop_ok), .ready(ready)
);

// File: tb/dram_selfref_seq_tb.sv
`timescale 1ns/1ps
module dram_selfref_seq_tb;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req = 0, wake_req = 0, clk_stable = 1, odt_req = 1;
  logic [W-1:0] c_pre = 2, c_min = 2, c_xc = 2, c_xh = 2, c_rw = 2;
  logic cs_n, ras_n, cas_n, we_n, cke, odt, clk_stop_ok, ready;

  dram_selfref_seq #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .clk_stable(clk_stable), .odt_req(odt_req),
    .cfg_pre_wait(c_pre), .cfg_min_sleep(c_min), .cfg_exit_cmd(c_xc),
    .cfg_exit_hold(c_xh), .cfg_ref_wait(c_rw),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke),
    .odt(odt), .clk_stop_ok(clk_stop_ok), .ready(ready)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int checks = 0, failures = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // reference observer: event times and per-cycle protocol expectations
  int t_pre = -1, t_sre = -1, t_rise = -1, t_ref = -1, t_rdy = -1, n_ref = 0;
  bit sleeping = 0, exiting = 0, prev_cke = 1, prev_rdy = 1, mon_on = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      logic [3:0] code;
      code = {cs_n, ras_n, cas_n, we_n};
      if (code == 4'b0010) t_pre = cyc;
      if (code == 4'b0001 && !cke) begin t_sre = cyc; sleeping = 1; end
      if (cke && !prev_cke) begin t_rise = cyc; sleeping = 0; exiting = 1; end
      if (code == 4'b0001 && cke) begin t_ref = cyc; exiting = 0; n_ref++; end
      else if (exiting) chk(code == 4'b0111, "R7", "nop during exit", code, 4'b0111);
      if (ready && !prev_rdy) t_rdy = cyc;
      chk(odt == ready, "R4", "odt follows ready", odt, ready);
      chk(clk_stop_ok == (sleeping && cyc > t_sre && !wake_req), "R6", "clk_stop_ok",
          clk_stop_ok, sleeping && cyc > t_sre && !wake_req);
      chk(cke == !sleeping, "R9", "cke level", cke, !sleeping);
      prev_cke = cke;
      prev_rdy = ready;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic round(input int pw, input int ms, input int xc, input int xh, input int rw,
                       input int wdel, input int sdel, input bit hold);
    int s, w, v, exp_rise, exp_ref, exp_rdy, exp_pre2, nref0;
    c_pre = W'(pw); c_min = W'(ms); c_xc = W'(xc); c_xh = W'(xh); c_rw = W'(rw);
    tick();
    t_pre = -1; t_sre = -1; t_rise = -1; t_ref = -1; t_rdy = -1; nref0 = n_ref;
    sleep_req = 1; s = cyc;
    while (t_sre < 0) tick();
    chk(t_pre == s + 1, "R2", "precharge cycle", t_pre, s + 1);
    chk(t_sre == t_pre + mx(pw, 2), "R3", "entry cycle", t_sre, t_pre + mx(pw, 2));
    t_pre = -1;
    if (sdel > 0) clk_stable = 0;
    if (!hold) sleep_req = 0;
    repeat (wdel) tick();
    wake_req = 1; w = cyc; v = 0;
    if (sdel > 0) begin repeat (sdel) tick(); clk_stable = 1; v = cyc; end
    while (t_rise < 0) tick();
    wake_req = 0;
    exp_rise = mx(t_sre + mx(ms, 2), mx(w, v) + 1);
    chk(t_rise == exp_rise, "R5", "cke rise cycle", t_rise, exp_rise);
    while (t_rdy < 0) tick();
    exp_ref = t_rise + mx(xc, 1);
    chk(t_ref == exp_ref, "R7", "refresh cycle", t_ref, exp_ref);
    chk(n_ref == nref0 + 1, "R8", "one refresh per exit", n_ref - nref0, 1);
    exp_rdy = mx(t_ref + 1, t_rise + mx(xh - 1, 0));
    chk(t_rdy == exp_rdy, "R9", "ready rise cycle", t_rdy, exp_rdy);
    if (hold) begin
      exp_pre2 = mx(t_ref + mx(rw - 1, 1), t_rise + mx(xh - 1, 0)) + 2;
      while (t_pre < 0) tick();
      chk(t_pre == exp_pre2, "R10", "held request re-entry", t_pre, exp_pre2);
      sleep_req = 0;
      t_sre = -1; t_rdy = -1;
      while (t_sre < 0) tick();
      wake_req = 1;
      while (t_rdy < 0) tick();
      wake_req = 0;
    end
    repeat (3) tick();
    chk(ready == 1'b1, "R9", "ready held after exit", ready, 1);
  endtask

  initial begin
    wait (cyc >= 20000);
    failures++;
    $display("FAIL watchdog R1 act=%0d exp=%0d", cyc, 20000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(ready == 1, "R1", "reset ready", ready, 1);
    chk(cke == 1, "R1", "reset cke", cke, 1);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "reset nop", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk(clk_stop_ok == 0, "R1", "reset clk_stop_ok", clk_stop_ok, 0);
    mon_on = 1;
    tick();
    wake_req = 1;
    repeat (3) begin
      @(negedge clk);
      chk(cke == 1 && ready == 1 && {cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1",
          "wake ignored in ready", {cke, ready}, 3);
    end
    tick();
    wake_req = 0;
    round(3, 5, 6, 10, 4, 0, 0, 0);
    round(1, 1, 1, 1, 1, 4, 0, 0);
    round(2, 3, 4, 2, 3, 2, 5, 0);
    round(2, 2, 3, 20, 2, 0, 0, 1);
    round(2, 2, 2, 1, 9, 0, 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule